// File: doc/BRIEF.md
# Serial-Armed Frame Capture and Dump Sequencer

This controller runs one capture-and-readout cycle for a frame grabber that talks to a host over a serial link. A host arms it by sending any character on the receive line; the value of the character does not matter. A pushbutton pulse can arm it as well. Once armed, it waits for the next rising edge of the display's frame-start sync. At that edge it tells the capture engine to store the frame, and then it waits for the engine to report that the frame is in memory.

Readout reuses the address counters that the capture engine already has. The sequencer issues one pseudo frame-sync pulse, which clears those counters. For each pixel it then reads one 18-bit memory word and transmits the three 6-bit colour components as three serial bytes. After the third byte it pulses an advance strobe, which steps the counters to the next address. After a fixed number of pixels it returns to idle and needs a new arm before it will capture again.

Top module: `capdump_ctrl`

## Requirements
- R1: After reset the sequencer is idle. `txd_o` is high, and `cap_go_o`, `pvsync_o`, `rd_en_o` and `adv_o` are all low.
- R2: In idle, the receive line arms the sequencer once its two-flop-synchronised level has been low for `CLK_PER_BIT/2` consecutive clock cycles. A shorter low glitch does not arm it, and the value of any character sent is irrelevant.
- R3: In idle, a one-cycle high pulse on `arm_btn_i` arms the sequencer.
- R4: When armed, `cap_go_o` is high for exactly one cycle, in the cycle after the first clock edge at which `vsync_i` is seen rising. A sync level that is already high when the sequencer is armed does not start a capture.
- R5: `frame_done_i` is ignored unless a capture is in progress. During a capture it starts the dump, and `pvsync_o` is high for the cycle right after it.
- R6: During the dump, `rd_en_o` pulses once per pixel, and the word on `rd_data_i` is taken one cycle later. `adv_o` pulses once after each pixel's third byte. Exactly `PIXELS` pixels are read. At most one of `cap_go_o`, `pvsync_o`, `rd_en_o` and `adv_o` is high in any cycle.
- R7: Each byte is sent as an 8N1 frame: a low start bit, 8 data bits LSB first, and a high stop bit, each lasting `CLK_PER_BIT` cycles. The line idles high.
- R8: The bytes of each pixel are sent in the order red (word bits [17:12]), green (bits [11:6]), blue (bits [5:0]). Each colour value is in bits [5:0] of its byte, and bits [7:6] are zero.
- R9: Activity on the receive line and on the arm button is ignored during capture and dump. After the last byte the sequencer returns to idle, so a later sync edge or frame-done does nothing until it is armed again. `txd_o` stays high outside the dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd_i | input | 1 | Serial receive line from host, idle high |
| arm_btn_i | input | 1 | One-cycle arm pulse from pushbutton logic |
| vsync_i | input | 1 | Display frame-start sync, synchronous to clk |
| cap_go_o | output | 1 | One-cycle pulse telling the capture engine to store this frame |
| frame_done_i | input | 1 | Pulse from the capture engine when the frame is stored |
| pvsync_o | output | 1 | Pseudo frame-sync pulse that clears the address counters |
| adv_o | output | 1 | Pulse that advances the address counters by one pixel |
| rd_en_o | output | 1 | Memory read strobe at the current counter address |
| rd_data_i | input | 3*COLOR_W | Memory read word, valid one cycle after rd_en_o |
| txd_o | output | 1 | Serial transmit line to host |

## Verification
Some properties are checked by assertions on every cycle. These are: the four strobes never overlap; a capture strobe always follows a rising sync edge; the word is latched only one cycle after a read; the transmitter is started only when it is idle; and the transmit line stays high outside the dump. Other behaviour only the bench scenarios can show: the glitch threshold on the receive line, arming by button while the sync is already high, and a frame-done that arrives too early and is ignored. The bench also checks that arming attempts during a dump leave no trace. Its decoded byte stream is compared, in order, against pixel values computed from the bench's own model of the counters and memory.

// File: rtl/capdump_pkg.sv
package capdump_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAPT,
        ST_DUMP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_SYNC,
        PH_READ,
        PH_LATCH,
        PH_SEND,
        PH_WAIT,
        PH_ADV
    } dump_phase_e;

endpackage

// File: rtl/capdump_arm_det.sv
module capdump_arm_det #(
    parameter int CLK_PER_BIT = 217
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic enable_i,
    output logic arm_o
);
    localparam int HALF = (CLK_PER_BIT / 2 > 0) ? CLK_PER_BIT / 2 : 1;
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          arm;
    } arm_regs_t;

    localparam arm_regs_t RST = '{s1: 1'b1, s2: 1'b1, cnt: '0, arm: 1'b0};

    arm_regs_t q, d;

    always_comb begin
        d     = q;
        d.s1  = rxd_i;
        d.s2  = q.s1;
        d.arm = 1'b0;
        if (!enable_i || q.s2) begin
            d.cnt = '0;
        end else if (q.cnt == HALF_M1) begin
            d.arm = 1'b1;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign arm_o = q.arm;

    AST_ARM_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        arm_o |-> $past(enable_i)) else $error("arm outside idle"); // R9

endmodule

// File: rtl/capdump_tx.sv
module capdump_tx #(
    parameter int CLK_PER_BIT = 217,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              txd_o,
    output logic              done_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int TW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam int BW = $clog2(FRAME_W);
    localparam logic [TW-1:0] TICK_LAST = TW'(CLK_PER_BIT - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [TW-1:0]      tick;
        logic [BW-1:0]      bitn;
        logic               done;
    } tx_regs_t;

    localparam tx_regs_t RST = '{busy: 1'b0, sh: '1, tick: '0, bitn: '0, done: 1'b0};

    tx_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, data_i, 1'b0};
                d.tick = '0;
                d.bitn = '0;
            end
        end else if (q.tick == TICK_LAST) begin
            d.tick = '0;
            if (q.bitn == BIT_LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.bitn = q.bitn + 1'b1;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
            end
        end else begin
            d.tick = q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign txd_o  = q.busy ? q.sh[0] : 1'b1;
    assign done_o = q.done;

    AST_TX_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.busy) else $error("start while busy"); // R7

    AST_TX_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.busy) && !q.busy)) else $error("done without frame"); // R7

endmodule

// File: rtl/capdump_ctrl.sv
module capdump_ctrl
    import capdump_pkg::*;
#(
    parameter int CLK_PER_BIT = 217,
    parameter int COLOR_W     = 6,
    parameter int PIXELS      = 49152
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd_i,
    input  logic                 arm_btn_i,
    input  logic                 vsync_i,
    output logic                 cap_go_o,
    input  logic                 frame_done_i,
    output logic                 pvsync_o,
    output logic                 adv_o,
    output logic                 rd_en_o,
    input  logic [3*COLOR_W-1:0] rd_data_i,
    output logic                 txd_o
);
    localparam int PIX_W  = 3 * COLOR_W;
    localparam int BYTE_W = 8;
    localparam int PCW    = (PIXELS > 1) ? $clog2(PIXELS) : 1;
    localparam logic [PCW-1:0] PCNT_LAST = PCW'(PIXELS - 1);

    typedef struct packed {
        seq_state_e  state;
        dump_phase_e phase;
        logic        vs;
        logic        cap_go;
        logic [PIX_W-1:0] pix;
        logic [1:0]  sel;
        logic [PCW-1:0] pcnt;
    } seq_regs_t;

    localparam seq_regs_t RST = '{state: ST_IDLE, phase: PH_SYNC, vs: 1'b0,
                                  cap_go: 1'b0, pix: '0, sel: '0, pcnt: '0};

    seq_regs_t q, d;

    logic              rx_arm;
    logic              tx_start;
    logic              tx_done;
    logic [COLOR_W-1:0] color;
    logic [BYTE_W-1:0] tx_byte;

    capdump_arm_det #(.CLK_PER_BIT(CLK_PER_BIT)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd_i    (rxd_i),
        .enable_i (q.state == ST_IDLE),
        .arm_o    (rx_arm)
    );

    capdump_tx #(.CLK_PER_BIT(CLK_PER_BIT), .DATA_W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (tx_byte),
        .txd_o   (txd_o),
        .done_o  (tx_done)
    );

    always_comb begin
        case (q.sel)
            2'd0:    color = q.pix[PIX_W-1 -: COLOR_W];
            2'd1:    color = q.pix[2*COLOR_W-1 -: COLOR_W];
            default: color = q.pix[COLOR_W-1:0];
        endcase
        tx_byte = BYTE_W'(color);
    end

    always_comb begin
        d        = q;
        d.vs     = vsync_i;
        d.cap_go = 1'b0;
        tx_start = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (rx_arm || arm_btn_i) d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (vsync_i && !q.vs) begin
                    d.state  = ST_CAPT;
                    d.cap_go = 1'b1;
                end
            end
            ST_CAPT: begin
                if (frame_done_i) begin
                    d.state = ST_DUMP;
                    d.phase = PH_SYNC;
                    d.pcnt  = '0;
                end
            end
            ST_DUMP: begin
                case (q.phase)
                    PH_SYNC:  d.phase = PH_READ;
                    PH_READ:  d.phase = PH_LATCH;
                    PH_LATCH: begin
                        d.pix   = rd_data_i;
                        d.sel   = 2'd0;
                        d.phase = PH_SEND;
                    end
                    PH_SEND: begin
                        tx_start = 1'b1;
                        d.phase  = PH_WAIT;
                    end
                    PH_WAIT: begin
                        if (tx_done) begin
                            if (q.sel == 2'd2) begin
                                d.phase = PH_ADV;
                            end else begin
                                d.sel   = q.sel + 2'd1;
                                d.phase = PH_SEND;
                            end
                        end
                    end
                    PH_ADV: begin
                        if (q.pcnt == PCNT_LAST) begin
                            d.state = ST_DONE;
                        end else begin
                            d.pcnt  = q.pcnt + 1'b1;
                            d.phase = PH_READ;
                        end
                    end
                    default: d.phase = PH_SYNC;
                endcase
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cap_go_o = q.cap_go;
    assign pvsync_o = (q.state == ST_DUMP) && (q.phase == PH_SYNC);
    assign rd_en_o  = (q.state == ST_DUMP) && (q.phase == PH_READ);
    assign adv_o    = (q.state == ST_DUMP) && (q.phase == PH_ADV);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_go_o, pvsync_o, rd_en_o, adv_o})) else $error("strobe overlap"); // R6

    AST_CAPGO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_go_o |-> ($past(vsync_i) && !$past(vsync_i, 2))) else $error("capture without edge"); // R4

    AST_LATCH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DUMP && q.phase == PH_LATCH) |-> $past(rd_en_o)) else $error("latch without read"); // R6

    AST_TXD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_DUMP) |-> txd_o) else $error("txd active outside dump"); // R9

    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= PCNT_LAST) else $error("pixel count overflow"); // R6

endmodule

// File: tb/tb_capdump_ctrl.sv
module tb_capdump_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int CW         = 6;
    localparam int PIX        = 5;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic arm_btn = 1'b0;
    logic vsync = 1'b0;
    logic frame_done = 1'b0;
    logic cap_go, pvsync, adv, rd_en, txd;
    logic [3*CW-1:0] rd_data = '0;

    int checks = 0;
    int errors = 0;
    int seed = 0;
    int maddr = 0;
    int n_go = 0, n_pv = 0, n_rd = 0, n_adv = 0;
    int cyc = 0;
    bit expect_quiet = 1'b1;
    bit finished = 1'b0;
    byte got[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    capdump_ctrl #(.CLK_PER_BIT(CPB), .COLOR_W(CW), .PIXELS(PIX)) dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .arm_btn_i(arm_btn),
        .vsync_i(vsync), .cap_go_o(cap_go), .frame_done_i(frame_done),
        .pvsync_o(pvsync), .adv_o(adv), .rd_en_o(rd_en),
        .rd_data_i(rd_data), .txd_o(txd)
    );

    function automatic logic [3*CW-1:0] pix_of(int a, int s);
        logic [CW-1:0] r, g, b;
        r = CW'(a * 7 + s * 13 + 3);
        g = CW'(63 - a * 5 - s);
        b = CW'(a * a + s * 29);
        return {r, g, b};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bench model of the address counters and memory with one cycle of latency
    always @(posedge clk) begin
        if (pvsync) maddr <= 0;
        else if (adv) maddr <= maddr + 1;
        if (rd_en) rd_data <= pix_of(maddr, seed);
    end

    // per-clock observation: strobe counts, idle line, watchdog
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            n_go  += int'(cap_go);
            n_pv  += int'(pvsync);
            n_rd  += int'(rd_en);
            n_adv += int'(adv);
            if (expect_quiet) chk(txd === 1'b1, "R9", int'(txd), 1, "txd outside dump");
        end
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // serial line decoder: sample each bit at its middle
    bit mbusy = 1'b0;
    bit mprev = 1'b1;
    int mcnt = 0;
    logic [7:0] mbyte = '0;
    always @(negedge clk) begin
        if (!mbusy) begin
            if (txd === 1'b0 && mprev) begin
                mbusy = 1'b1;
                mcnt = 0;
            end
        end else begin
            mcnt++;
            if (mcnt >= CPB / 2 && (mcnt - CPB / 2) % CPB == 0) begin
                int k;
                k = (mcnt - CPB / 2) / CPB;
                if (k == 0) chk(txd === 1'b0, "R7", int'(txd), 0, "start bit");
                else if (k <= 8) mbyte[k-1] = txd;
                else begin
                    chk(txd === 1'b1, "R7", int'(txd), 1, "stop bit");
                    got.push_back(mbyte);
                    mbusy = 1'b0;
                end
            end
        end
        mprev = txd;
    end

    task automatic send_char(logic [7:0] v);
        logic [9:0] fr;
        fr = {1'b1, v, 1'b0};
        for (int b = 0; b < 10; b++) begin
            rxd = fr[b];
            tick(CPB);
        end
        rxd = 1'b1;
    endtask

    task automatic vsync_rise_expect_go(string req);
        vsync = 1'b1;
        tick();
        chk(cap_go === 1'b1, req, int'(cap_go), 1, "cap_go after sync edge");
        tick();
        chk(cap_go === 1'b0, req, int'(cap_go), 0, "cap_go one cycle");
        tick(3);
        vsync = 1'b0;
        tick(2);
    endtask

    task automatic run_dump(int s, bit poke);
        int pv0, rd0, adv0;
        pv0 = n_pv; rd0 = n_rd; adv0 = n_adv;
        seed = s;
        got.delete();
        expect_quiet = 1'b0;
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        chk(pvsync === 1'b1, "R5", int'(pvsync), 1, "pseudo sync after frame done");
        if (poke) begin
            // R9: arming attempts while dumping
            rxd = 1'b0;
            arm_btn = 1'b1;
            tick();
            arm_btn = 1'b0;
            tick(2 * CPB);
            rxd = 1'b1;
        end
        for (int w = 0; w < 40 * CPB * PIX && got.size() < 3 * PIX; w++) tick();
        tick(3 * CPB);
        expect_quiet = 1'b1;
        chk(got.size() == 3 * PIX, "R6", got.size(), 3 * PIX, "bytes received");
        for (int p = 0; p < PIX; p++) begin
            logic [3*CW-1:0] w;
            w = pix_of(p, s);
            for (int c = 0; c < 3; c++) begin
                logic [7:0] e;
                e = 8'(w[3*CW-1-c*CW -: CW]);
                if (3 * p + c < got.size())
                    chk(got[3*p+c] == e, "R8", int'(got[3*p+c]), int'(e), "pixel byte");
            end
        end
        chk(n_rd - rd0 == PIX, "R6", n_rd - rd0, PIX, "read strobes");
        chk(n_adv - adv0 == PIX, "R6", n_adv - adv0, PIX, "advance strobes");
        chk(n_pv - pv0 == 1, "R5", n_pv - pv0, 1, "pseudo sync pulses");
    endtask

    initial begin
        int go0, pv0;
        tick(5);
        rst_n = 1'b1;
        tick();
        chk(txd === 1'b1, "R1", int'(txd), 1, "txd after reset");
        chk(cap_go === 1'b0, "R1", int'(cap_go), 0, "cap_go after reset");
        chk(rd_en === 1'b0 && pvsync === 1'b0 && adv === 1'b0, "R1",
            int'({rd_en, pvsync, adv}), 0, "strobes after reset");

        // R2: a glitch shorter than half a bit does not arm
        rxd = 1'b0;
        tick(CPB / 2 - 1);
        rxd = 1'b1;
        tick(10);
        vsync = 1'b1; tick(3); vsync = 1'b0; tick(5);
        chk(n_go == 0, "R2", n_go, 0, "capture after glitch");

        // R2: a full character arms; the capture waits for the sync edge (R4)
        send_char(8'hF0);
        tick(5);
        chk(n_go == 0, "R4", n_go, 0, "capture before sync edge");
        vsync_rise_expect_go("R4");
        run_dump(1, 1'b1);

        // R9: back in idle; sync edge and frame done do nothing
        go0 = n_go; pv0 = n_pv;
        vsync = 1'b1; tick(3); vsync = 1'b0; tick(3);
        frame_done = 1'b1; tick(); frame_done = 1'b0; tick(5);
        chk(n_go == go0, "R9", n_go - go0, 0, "capture without new arm");
        chk(n_pv == pv0, "R9", n_pv - pv0, 0, "dump without new arm");

        // R3: button arm while sync already high (R4 level ignored)
        vsync = 1'b1;
        tick(2);
        arm_btn = 1'b1; tick(); arm_btn = 1'b0;
        tick(10);
        chk(n_go == go0, "R4", n_go - go0, 0, "capture on sync level");
        // R5: frame done while only armed is ignored
        frame_done = 1'b1; tick(); frame_done = 1'b0; tick(5);
        chk(n_pv == pv0, "R5", n_pv - pv0, 0, "dump from armed state");
        vsync = 1'b0; tick(2);
        vsync_rise_expect_go("R3");
        run_dump(2, 1'b0);

        // R2 boundary: exactly half a bit of low arms
        rxd = 1'b0;
        tick(CPB / 2);
        rxd = 1'b1;
        tick(8);
        vsync_rise_expect_go("R2");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule